// File: doc/BRIEF.md
# Predetermining BCD Up/Down Counter

The block is a six-decade synchronous decimal counter that moves up or down on count strobes. A prescaler in front of it passes every strobe, every fifth strobe or every sixth strobe. Three stored values are loaded over a small parallel port and compared against the live count: an early-warning value, a terminal value and a preset value. A fourth comparison looks for zero. Each comparison drives a flag output.

The counter can reload itself. Counting up, it clears once it reaches the terminal value. Counting down, it reloads the preset value once it reaches zero. In these automatic cases the flag in question is high for one clock only. When the automatic action is inhibited, the count stays where it is and the flag stays high until the count moves on.

The whole block runs from one system clock. The count input is a strobe that is already synchronised and lasts one clock.

Top module: `bcd_preset_counter`

## Requirements
- R1: While `rst_n` is low and after its release, the count and all three stores are zero. `zero_flag`, `main_flag` and `pre_flag` are therefore all high until the first change.
- R2: The prescaler ratio comes from `div_sel` as {sel1, sel2}. 2'b00 and 2'b01 divide by 5, 2'b10 divides by 6, and 2'b11 passes every strobe. With ratio N, the count moves on the edge that samples the N-th accepted strobe.
- R3: The count is kept as six 4-bit BCD digits, with the least significant digit in bits [3:0]. Counting up, a digit goes from 9 to 0 and carries into the next digit. Counting down, a digit goes from 0 to 9 and borrows. The full count wraps 999999→0 going up and 0→999999 going down.
- R4: A strobe sampled while `cnt_hold` is high has no effect on the count or on the prescaler phase.
- R5: `clr` high zeroes the count and the prescaler phase on the next edge, and keeps them there. It takes priority over every other action.
- R6: `load_pre` high (with `clr` low) copies the preset store into the count and keeps it there. It takes priority over the automatic actions and over counting.
- R7: `store_we` writes `store_data` into the store chosen by `store_sel`: 2'b01 early-warning, 2'b10 terminal, 2'b11 preset. 2'b00 writes nothing.
- R8: With `cnt_up` high and `no_auto_clr` low, a count equal to the terminal store is cleared on the next edge, so `main_flag` is high for exactly one clock.
- R9: With `no_auto_clr` high, `main_flag` stays high after a terminal match until the next counted step or a clear.
- R10: With `cnt_up` low and `no_auto_load` low, a zero count loads the preset store on the next edge, so `zero_flag` is high for exactly one clock.
- R11: With `no_auto_load` high, a zero count stays at zero until a preset or a counted step. `zero_flag` is high whenever the count is zero.
- R12: `pre_flag` is high exactly while the count equals the early-warning store. It therefore stays high until the next step, a clear or a preset.
- R13: An automatic clear or reload takes priority over a counted step in the same clock. That step is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_stb | input | 1 | One-clock count strobe |
| cnt_up | input | 1 | 1 counts up, 0 counts down |
| cnt_hold | input | 1 | Ignores strobes while high |
| clr | input | 1 | Synchronous clear of count and prescaler |
| load_pre | input | 1 | Loads and holds the preset store |
| div_sel | input | 2 | Prescaler ratio select {sel1, sel2} |
| no_auto_clr | input | 1 | Disables the automatic clear in up mode |
| no_auto_load | input | 1 | Disables the automatic reload in down mode |
| store_we | input | 1 | Store write strobe |
| store_sel | input | 2 | Store select for writes |
| store_data | input | 24 | BCD value to store |
| count | output | 24 | Current BCD count |
| main_flag | output | 1 | Count equals the terminal store |
| pre_flag | output | 1 | Count equals the early-warning store |
| zero_flag | output | 1 | Count is zero |

## Verification
The count is a register, and every action appears on `count` one edge after the inputs that cause it are sampled. The three flags are pure comparisons of the registered count with the registered stores, so they are due in the same window. An automatic clear or reload therefore shows its flag in the cycle after the matching step, and the cleared or reloaded count one edge later. The bench drives inputs at the falling edge, advances its decimal model at the rising edge, and compares the outputs 2 ns later. It covers every directed step and several thousand random cycles.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
  localparam int NIB  = 4;
  localparam int PH_W = 3;

  typedef enum logic [1:0] {
    ST_NONE   = 2'b00,
    ST_PSIG   = 2'b01,
    ST_MAIN   = 2'b10,
    ST_PRESET = 2'b11
  } store_sel_e;

  // {sel1, sel2}: 1x with sel2=1 -> 1, 10 -> 6, 0x -> 5
  function automatic logic [PH_W-1:0] div_ratio(input logic [1:0] sel);
    if (sel[1]) return sel[0] ? PH_W'(1) : PH_W'(6);
    return PH_W'(5);
  endfunction
endpackage

// File: rtl/bcd_prescaler.sv
module bcd_prescaler
  import bcd_cnt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       stb,
  input  logic [1:0] div_sel,
  output logic       tick
);
  logic [PH_W-1:0] ph_q, ph_d, lim;

  always_comb begin
    lim  = div_ratio(div_sel) - PH_W'(1);
    ph_d = ph_q;
    tick = 1'b0;
    if (clr) begin
      ph_d = '0;
    end else if (stb) begin
      if (ph_q >= lim) begin
        ph_d = '0;
        tick = 1'b1;
      end else begin
        ph_d = ph_q + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ph_q <= '0;
    else if (clr || stb) ph_q <= ph_d;
  end

  a_r2_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q <= lim) |=> (ph_q < PH_W'(6)));
endmodule

// File: rtl/bcd_decade.sv
module bcd_decade
  import bcd_cnt_pkg::*;
(
  input  logic [NIB-1:0] d,
  input  logic           up,
  input  logic           cin,
  output logic [NIB-1:0] dn,
  output logic           cout
);
  logic at_end;

  always_comb begin
    at_end = up ? (d == NIB'(9)) : (d == '0);
    cout   = cin & at_end;
    dn     = d;
    if (cin) begin
      if (up) dn = at_end ? '0 : d + NIB'(1);
      else    dn = at_end ? NIB'(9) : d - NIB'(1);
    end
  end
endmodule

// File: rtl/bcd_store_bank.sv
module bcd_store_bank
  import bcd_cnt_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [1:0]   sel,
  input  logic [W-1:0] data,
  output logic [W-1:0] psig_q,
  output logic [W-1:0] main_q,
  output logic [W-1:0] preset_q
);
  logic we_psig, we_main, we_preset;

  always_comb begin
    we_psig   = we && (store_sel_e'(sel) == ST_PSIG);
    we_main   = we && (store_sel_e'(sel) == ST_MAIN);
    we_preset = we && (store_sel_e'(sel) == ST_PRESET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psig_q   <= '0;
      main_q   <= '0;
      preset_q <= '0;
    end else begin
      if (we_psig)   psig_q   <= data;
      if (we_main)   main_q   <= data;
      if (we_preset) preset_q <= data;
    end
  end

  a_r7_none_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == 2'b00) |=> ($stable(psig_q) && $stable(main_q) && $stable(preset_q)));
endmodule

// File: rtl/bcd_preset_counter.sv
module bcd_preset_counter
  import bcd_cnt_pkg::*;
#(
  parameter int DIGITS = 6,
  localparam int W = NIB * DIGITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_stb,
  input  logic         cnt_up,
  input  logic         cnt_hold,
  input  logic         clr,
  input  logic         load_pre,
  input  logic [1:0]   div_sel,
  input  logic         no_auto_clr,
  input  logic         no_auto_load,
  input  logic         store_we,
  input  logic [1:0]   store_sel,
  input  logic [W-1:0] store_data,
  output logic [W-1:0] count,
  output logic         main_flag,
  output logic         pre_flag,
  output logic         zero_flag
);
  logic [W-1:0]    cnt_q, cnt_d, stepped;
  logic [W-1:0]    psig_q, main_q, preset_q;
  logic [DIGITS:0] cy;
  logic            tick, auto_clr, auto_load, cnt_en;

  bcd_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .stb(cnt_stb & ~cnt_hold), .div_sel(div_sel), .tick(tick)
  );

  bcd_store_bank #(.W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(store_we), .sel(store_sel), .data(store_data),
    .psig_q(psig_q), .main_q(main_q), .preset_q(preset_q)
  );

  assign cy[0] = tick;
  for (genvar g = 0; g < DIGITS; g++) begin : g_dec
    bcd_decade u_dec (
      .d(cnt_q[g*NIB +: NIB]), .up(cnt_up), .cin(cy[g]),
      .dn(stepped[g*NIB +: NIB]), .cout(cy[g+1])
    );
    a_r3_digit_bcd: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[g*NIB +: NIB] <= NIB'(9) && preset_q[g*NIB +: NIB] <= NIB'(9))
      |=> (cnt_q[g*NIB +: NIB] <= NIB'(9)));
  end

  always_comb begin
    main_flag = (cnt_q == main_q);
    pre_flag  = (cnt_q == psig_q);
    zero_flag = (cnt_q == '0);
    auto_clr  = cnt_up && !no_auto_clr && main_flag;
    auto_load = !cnt_up && !no_auto_load && zero_flag;
    cnt_en    = clr || load_pre || auto_clr || auto_load || tick;
    if (clr)            cnt_d = '0;
    else if (load_pre)  cnt_d = preset_q;
    else if (auto_clr)  cnt_d = '0;
    else if (auto_load) cnt_d = preset_q;
    else                cnt_d = stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> zero_flag);
  a_r6_preset_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_pre && !store_we) |=> (cnt_q == preset_q));
  a_r8_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (main_flag && cnt_up && !no_auto_clr && !clr && !load_pre) |=> zero_flag);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_hold && !clr && !load_pre && !auto_clr && !auto_load) |=> $stable(cnt_q));
  a_r11_zero_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_flag && !cnt_up && no_auto_load && !clr && !load_pre && !tick) |=> zero_flag);
endmodule

// File: tb/bcd_preset_counter_test.sv
`timescale 1ns/1ps
module bcd_preset_counter_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic stb = 0, up = 1, hold = 0, clr = 0, ld = 0, nac = 1, nal = 1, we = 0;
  logic [1:0] dsel = 2'b11, ssel = 2'b00;
  logic [23:0] sdat = '0;
  logic [23:0] count;
  logic main_flag, pre_flag, zero_flag;
  int n_chk = 0, n_fail = 0;
  int m_cnt = 0, m_main = 0, m_psig = 0, m_preset = 0, m_ph = 0;

  always #10 clk = ~clk;

  bcd_preset_counter uut (
    .clk(clk), .rst_n(rst_n), .cnt_stb(stb), .cnt_up(up), .cnt_hold(hold),
    .clr(clr), .load_pre(ld), .div_sel(dsel), .no_auto_clr(nac), .no_auto_load(nal),
    .store_we(we), .store_sel(ssel), .store_data(sdat), .count(count),
    .main_flag(main_flag), .pre_flag(pre_flag), .zero_flag(zero_flag)
  );

  function automatic logic [23:0] to_bcd(input int v);
    logic [23:0] r;
    int x = v;
    for (int i = 0; i < 6; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic int ratio(input logic [1:0] s);
    return s[1] ? (s[0] ? 1 : 6) : 5;
  endfunction

  task automatic check(input string tag);
    logic [2:0] ef;
    ef = {m_cnt == m_main, m_cnt == m_psig, m_cnt == 0};
    n_chk++;
    if (count !== to_bcd(m_cnt)) begin
      n_fail++;
      $display("FAIL %s count actual %h expected %h", tag, count, to_bcd(m_cnt));
    end
    n_chk++;
    if ({main_flag, pre_flag, zero_flag} !== ef) begin
      n_fail++;
      $display("FAIL %s flags actual %b expected %b", tag, {main_flag, pre_flag, zero_flag}, ef);
    end
  endtask

  // Advance one clock: model follows the requirements in decimal
  task automatic step(input string tag);
    bit tk, ac, al;
    @(posedge clk);
    tk = 0;
    ac = up && !nac && (m_cnt == m_main);
    al = !up && !nal && (m_cnt == 0);
    if (clr) m_ph = 0;
    else if (stb && !hold) begin
      if (m_ph + 1 >= ratio(dsel)) begin m_ph = 0; tk = 1; end
      else m_ph++;
    end
    if (clr) m_cnt = 0;
    else if (ld) m_cnt = m_preset;
    else if (ac) m_cnt = 0;
    else if (al) m_cnt = m_preset;
    else if (tk) m_cnt = up ? (m_cnt + 1) % 1000000 : (m_cnt + 999999) % 1000000;
    if (we) begin
      case (ssel)
        2'b01: m_psig = bcd_val(sdat);
        2'b10: m_main = bcd_val(sdat);
        2'b11: m_preset = bcd_val(sdat);
        default: ;
      endcase
    end
    #2;
    check(tag);
    @(negedge clk);
  endtask

  function automatic int bcd_val(input logic [23:0] b);
    int v = 0;
    for (int i = 5; i >= 0; i--) v = v * 10 + int'(b[4*i +: 4]);
    return v;
  endfunction

  task automatic quiet();
    stb = 0; we = 0; clr = 0; ld = 0; hold = 0;
  endtask

  task automatic wr(input logic [1:0] s, input int v);
    quiet(); we = 1; ssel = s; sdat = to_bcd(v);
    step("R7");
    we = 0;
  endtask

  task automatic pulses(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      quiet(); stb = 1; step(tag);
    end
    stb = 0;
  endtask

  initial begin : watchdog
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1;
    check("R1");
    // R7 store loads, sel 00 writes nothing
    wr(2'b01, 5); wr(2'b10, 12); wr(2'b11, 7); wr(2'b00, 999999);
    quiet(); ld = 1; step("R7");
    quiet(); clr = 1; step("R5");
    // R9 manual up, R12 early warning
    quiet(); up = 1; nac = 1; dsel = 2'b11;
    pulses(5, "R12");
    pulses(7, "R3");
    quiet(); step("R9"); step("R9"); step("R9");
    pulses(1, "R9");
    // R8 automatic clear, R13 dropped strobe
    quiet(); clr = 1; step("R5");
    nac = 0;
    pulses(12, "R8");
    quiet(); stb = 1; step("R13");
    quiet(); step("R8");
    // R2 prescaler ratios
    dsel = 2'b00; pulses(4, "R2"); pulses(1, "R2");
    dsel = 2'b01; pulses(5, "R2");
    dsel = 2'b10; pulses(5, "R2"); pulses(1, "R2");
    dsel = 2'b11;
    // R4 hold
    quiet(); hold = 1; stb = 1; step("R4"); step("R4"); step("R4");
    hold = 0; stb = 0;
    // R6 preset holds even with strobes
    quiet(); ld = 1; step("R6"); stb = 1; step("R6"); step("R6");
    // R10 automatic reload down
    quiet(); up = 0; nal = 0;
    pulses(7, "R10");
    quiet(); step("R10"); step("R10");
    // R11 manual down stays at zero, then borrow wrap
    nal = 1;
    pulses(7, "R11");
    quiet(); step("R11"); step("R11");
    pulses(1, "R3");
    quiet(); up = 1; nac = 1;
    pulses(1, "R3");
    quiet(); up = 0; pulses(1, "R3"); up = 1;
    wr(2'b11, 99);
    quiet(); ld = 1; step("R6");
    pulses(1, "R3");
    // R5 clear wins over preset
    quiet(); clr = 1; ld = 1; step("R5");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      quiet();
      stb  = ($urandom % 2) == 0;
      hold = ($urandom % 8) == 0;
      clr  = ($urandom % 64) == 0;
      ld   = ($urandom % 40) == 0;
      if (($urandom % 16) == 0) begin
        we = 1; ssel = 2'($urandom); sdat = to_bcd(int'($urandom % 40));
      end
      if (($urandom % 30) == 0) up = ~up;
      if (($urandom % 50) == 0) nac = ~nac;
      if (($urandom % 50) == 0) nal = ~nal;
      if (($urandom % 80) == 0) dsel = 2'($urandom);
      step("R3");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule